// File: doc/BRIEF.md
# Frame-Synchronous Bit Clock Recovery

This block runs from a 15.36 MHz local oscillator and divides it by 80 to make a 192 kHz bit clock. The bit clock follows the timing of a received line stream. The receive side sends a one-cycle strobe each time it sees the framing-bit transition. The block compares that strobe with the start of its own bit period. If the error is outside a small dead band, the block lengthens or shortens one later bit period by one or two oscillator cycles. It makes at most one such comparison in each 48-bit frame.

The same divider chain also makes a 1.536 MHz reference clock (divide-by-10). That clock restarts at every bit boundary, so it stays in phase with the bit clock after every correction. The transmit clock is the recovered bit clock. A lock flag shows whether recent frames have needed no correction.

Top module: `clkrec_top`

## Requirements
- R1: Synchronous reset clears all counters and the lock state; all outputs are low while reset is applied. The bit clock first rises 40 cycles after the last clock edge that sampled reset high, and first falls 80 cycles after it.
- R2: With no corrections, the bit clock has a period of 80 oscillator cycles. It is low for cycles 0..39 of the period and high for cycles 40..79. A falling edge marks a bit boundary.
- R3: The reference clock is low at every falling edge of the bit clock. Its rising edges come exactly 5, 15, 25, ... cycles after the last bit boundary, even inside corrected periods.
- R4: A strobe is judged by the count c of cycles since the last bit boundary at the clock edge that samples it. If c < 40 the strobe is late by c cycles. Otherwise it is early by (length of the current period − c) cycles.
- R5: An error larger than 1 cycle lengthens (late) or shortens (early) the bit period that starts at the next boundary. The step is 1 cycle when step_sel=0 and 2 cycles when step_sel=1. The period in which the strobe arrives is not changed.
- R6: An error of 0 or 1 cycle gives no correction; the following period stays 80 cycles.
- R7: Frame windows are 48 bit periods long. The first begins at reset, and each later one begins at every 48th bit-clock falling edge. Only the first strobe in a window is measured; any later strobe in that window changes no period.
- R8: In windows without a strobe, the bit clock free-runs at 80 cycles per period.
- R9: The lock flag sets in the cycle after the fourth measured strobe in a row that needed no correction.
- R10: The lock flag clears after two measured strobes in a row that both need a correction in the same direction. A single correction, or two in opposite directions, leaves it set.
- R11: The transmit clock equals the bit clock in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 15.36 MHz oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_strobe | input | 1 | One-cycle pulse at the received framing-bit transition |
| step_sel | input | 1 | Correction size: 0 = one cycle, 1 = two cycles |
| bit_clk | output | 1 | Recovered 192 kHz bit clock |
| ref_clk | output | 1 | 1.536 MHz reference clock, aligned to bit boundaries |
| tx_clk | output | 1 | Transmit clock, equal to bit_clk |
| locked | output | 1 | Loop has settled with no recent corrections |

## Verification
Two things can happen in the same cycle: a strobe can be sampled and a bit period can end. The case that matters is a strobe sampled on the last cycle of a period (c = 79), where measurement and divider wrap share one edge. The bench places an early strobe exactly there. It expects no change from the dead band, and it expects the next period to be a clean 80 cycles with the reference still low at the boundary. Corrected periods of 78, 79, 81 and 82 cycles are also measured against the reference-edge spacing, which shows the reference divider restarts whenever the period length changes.

// File: rtl/clkrec_pkg.sv
package clkrec_pkg;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_LONG  = 2'd1,
        ADJ_SHORT = 2'd2
    } adj_e;

    typedef struct packed {
        adj_e       dir;
        logic [1:0] amt;
    } corr_t;

    function automatic corr_t corr_idle();
        corr_t c;
        c.dir = ADJ_NONE;
        c.amt = 2'd0;
        return c;
    endfunction

    function automatic logic [1:0] step_cycles(input logic sel);
        return sel ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/clkrec_bitdiv.sv
module clkrec_bitdiv
    import clkrec_pkg::*;
#(
    parameter int DIV_BIT    = 80,
    parameter int FRAME_BITS = 48,
    parameter int CW         = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  corr_t         corr_in,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] remain,
    output logic          wrap,
    output logic          frame_wrap,
    output logic          bclk
);
    localparam int FW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CW-1:0] TERM_NOM   = CW'(DIV_BIT - 1);
    localparam logic [CW-1:0] HALF_C     = CW'(DIV_BIT / 2);
    localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_BITS - 1);

    logic [CW-1:0] term;
    logic [FW-1:0] fcnt;
    corr_t         pend;
    corr_t         nxt;

    assign wrap       = (cnt == term);
    assign frame_wrap = wrap && (fcnt == FRAME_LAST);
    assign remain     = term - cnt + 1'b1;
    assign bclk       = (cnt >= HALF_C);
    assign nxt        = (corr_in.dir != ADJ_NONE) ? corr_in : pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            term <= TERM_NOM;
            fcnt <= '0;
            pend <= corr_idle();
        end else if (wrap) begin
            cnt  <= '0;
            pend <= corr_idle();
            fcnt <= (fcnt == FRAME_LAST) ? '0 : fcnt + 1'b1;
            case (nxt.dir)
                ADJ_LONG:  term <= TERM_NOM + {{(CW-2){1'b0}}, nxt.amt};
                ADJ_SHORT: term <= TERM_NOM - {{(CW-2){1'b0}}, nxt.amt};
                default:   term <= TERM_NOM;
            endcase
        end else begin
            cnt <= cnt + 1'b1;
            if (corr_in.dir != ADJ_NONE)
                pend <= corr_in;
        end
    end

    AST_TERM_RANGE: assert property (@(posedge clk) disable iff (rst)
        (term >= TERM_NOM - CW'(2)) && (term <= TERM_NOM + CW'(2))) // R5
        else $error("period terminal outside correction range");

endmodule

// File: rtl/clkrec_phase.sv
module clkrec_phase
    import clkrec_pkg::*;
#(
    parameter int DIV_BIT   = 80,
    parameter int DEAD_BAND = 1,
    parameter int CW        = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          step_sel,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] remain,
    input  logic          frame_wrap,
    output corr_t         corr,
    output logic          meas
);
    localparam logic [CW-1:0] HALF_C = CW'(DIV_BIT / 2);
    localparam logic [CW-1:0] DEAD_C = CW'(DEAD_BAND);

    logic          armed;
    logic          late;
    logic [CW-1:0] mag;

    assign meas = strobe && armed;
    assign late = (cnt < HALF_C);
    assign mag  = late ? cnt : remain;

    always_comb begin
        corr = corr_idle();
        if (meas && (mag > DEAD_C)) begin
            corr.dir = late ? ADJ_LONG : ADJ_SHORT;
            corr.amt = step_cycles(step_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b1;
        else if (frame_wrap)
            armed <= 1'b1;
        else if (meas)
            armed <= 1'b0;
    end

    AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
        (meas && !frame_wrap) |=> !meas) // R7
        else $error("second measurement inside one frame window");

endmodule

// File: rtl/clkrec_refdiv.sv
module clkrec_refdiv #(
    parameter int DIV_REF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    output logic refclk
);
    localparam int RW = $clog2(DIV_REF);
    localparam logic [RW-1:0] LAST_C = RW'(DIV_REF - 1);
    localparam logic [RW-1:0] HALF_C = RW'(DIV_REF / 2);

    logic [RW-1:0] rcnt;

    assign refclk = (rcnt >= HALF_C);

    always_ff @(posedge clk) begin
        if (rst || wrap)
            rcnt <= '0;
        else if (rcnt == LAST_C)
            rcnt <= '0;
        else
            rcnt <= rcnt + 1'b1;
    end

endmodule

// File: rtl/clkrec_lock.sv
module clkrec_lock
    import clkrec_pkg::*;
#(
    parameter int LOCK_QUIET = 4,
    parameter int UNLOCK_RUN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic meas,
    input  adj_e dir,
    output logic locked
);
    localparam int QW = $clog2(LOCK_QUIET + 1);
    localparam int NW = $clog2(UNLOCK_RUN + 1);
    localparam logic [QW-1:0] QMAX = QW'(LOCK_QUIET);
    localparam logic [QW-1:0] QSET = QW'(LOCK_QUIET - 1);
    localparam logic [NW-1:0] NMAX = NW'(UNLOCK_RUN);

    logic [QW-1:0] quiet;
    logic [NW-1:0] run;
    logic [NW-1:0] run_nxt;
    adj_e          last_dir;

    always_comb begin
        if (run != '0 && dir == last_dir)
            run_nxt = (run == NMAX) ? run : run + 1'b1;
        else
            run_nxt = NW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet    <= '0;
            run      <= '0;
            last_dir <= ADJ_NONE;
            locked   <= 1'b0;
        end else if (meas) begin
            if (dir == ADJ_NONE) begin
                run <= '0;
                if (quiet != QMAX)
                    quiet <= quiet + 1'b1;
                if (quiet >= QSET)
                    locked <= 1'b1;
            end else begin
                quiet    <= '0;
                run      <= run_nxt;
                last_dir <= dir;
                if (run_nxt >= NMAX)
                    locked <= 1'b0;
            end
        end
    end

    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(meas) && $past(dir == ADJ_NONE))) // R9
        else $error("lock set without a quiet measurement");

    AST_LOCK_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(meas) && $past(dir != ADJ_NONE))) // R10
        else $error("lock cleared without a correction");

endmodule

// File: rtl/clkrec_top.sv
module clkrec_top
    import clkrec_pkg::*;
#(
    parameter int DIV_BIT    = 80,
    parameter int DIV_REF    = 10,
    parameter int FRAME_BITS = 48,
    parameter int DEAD_BAND  = 1,
    parameter int LOCK_QUIET = 4,
    parameter int UNLOCK_RUN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frm_strobe,
    input  logic step_sel,
    output logic bit_clk,
    output logic ref_clk,
    output logic tx_clk,
    output logic locked
);
    localparam int CW = $clog2(DIV_BIT + 3);

    logic [CW-1:0] cnt;
    logic [CW-1:0] remain;
    logic          wrap;
    logic          frame_wrap;
    logic          meas;
    corr_t         corr;

    clkrec_bitdiv #(.DIV_BIT(DIV_BIT), .FRAME_BITS(FRAME_BITS), .CW(CW)) u_bitdiv (
        .clk(clk), .rst(rst), .corr_in(corr), .cnt(cnt), .remain(remain),
        .wrap(wrap), .frame_wrap(frame_wrap), .bclk(bit_clk)
    );

    clkrec_phase #(.DIV_BIT(DIV_BIT), .DEAD_BAND(DEAD_BAND), .CW(CW)) u_phase (
        .clk(clk), .rst(rst), .strobe(frm_strobe), .step_sel(step_sel),
        .cnt(cnt), .remain(remain), .frame_wrap(frame_wrap),
        .corr(corr), .meas(meas)
    );

    clkrec_refdiv #(.DIV_REF(DIV_REF)) u_refdiv (
        .clk(clk), .rst(rst), .wrap(wrap), .refclk(ref_clk)
    );

    clkrec_lock #(.LOCK_QUIET(LOCK_QUIET), .UNLOCK_RUN(UNLOCK_RUN)) u_lock (
        .clk(clk), .rst(rst), .meas(meas), .dir(corr.dir), .locked(locked)
    );

    assign tx_clk = bit_clk;

    AST_REF_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(bit_clk) |-> !ref_clk) // R3
        else $error("reference clock high at a bit boundary");

    AST_RESET_LOW: assert property (@(posedge clk)
        $past(rst) |-> (!bit_clk && !ref_clk && !locked)) // R1
        else $error("outputs not low after reset");

endmodule

// File: tb/clkrec_top_test.sv
`timescale 1ns/1ps
module clkrec_top_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frm_strobe = 1'b0;
    logic step_sel = 1'b0;
    logic bit_clk, ref_clk, tx_clk, locked;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int falls = 0;
    int last_fall_cyc = 0;
    int last_period = 0;
    int tx_err = 0;
    int ref_err = 0;
    bit fell_now = 1'b0;
    bit prev_b = 1'b0;
    bit prev_r = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkrec_top uut (
        .clk(clk), .rst(rst), .frm_strobe(frm_strobe), .step_sel(step_sel),
        .bit_clk(bit_clk), .ref_clk(ref_clk), .tx_clk(tx_clk), .locked(locked)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            fell_now = prev_b && !bit_clk;
            if (tx_clk !== bit_clk) tx_err = tx_err + 1;
            if (fell_now) begin
                last_period   = cyc - last_fall_cyc;
                last_fall_cyc = cyc;
                falls         = falls + 1;
                if (ref_clk) ref_err = ref_err + 1;
            end
            if (!prev_r && ref_clk && ((cyc - last_fall_cyc) % 10 != 5))
                ref_err = ref_err + 1;
            prev_b = bit_clk;
            prev_r = ref_clk;
        end else begin
            fell_now = 1'b0;
            prev_b = 1'b0;
            prev_r = 1'b0;
            falls = 0;
            last_fall_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_fall();
        do tick(); while (!fell_now);
    endtask

    task automatic wait_frame_start();
        do wait_fall(); while (falls % 48 != 0);
    endtask

    task automatic strobe_at(input int k, input bit st);
        wait_frame_start();
        repeat (k) tick();
        frm_strobe = 1'b1;
        step_sel   = st;
        tick();
        frm_strobe = 1'b0;
    endtask

    task automatic corr_case(input int k, input bit st, input int exp1, input string tag);
        int p0;
        strobe_at(k, st);
        if (!fell_now) wait_fall();
        p0 = last_period;
        check(p0 == 80, {tag, " strobe period unchanged"}, p0, 80);
        wait_fall();
        check(last_period == exp1, {tag, " following period"}, last_period, exp1);
    endtask

    task automatic test_reset();
        int n;
        repeat (3) tick();
        check(!bit_clk && !ref_clk && !tx_clk && !locked, "R1 outputs low in reset",
              {bit_clk, ref_clk, tx_clk, locked}, 0);
        rst = 1'b0;
        n = 0;
        do begin tick(); n++; end while (!bit_clk && n < 200);
        check(n == 40, "R1 first rise", n, 40);
        do begin tick(); n++; end while (!fell_now && n < 200);
        check(n == 80, "R1 first fall", n, 80);
        check(locked == 1'b0, "R1 lock clear", locked, 0);
    endtask

    task automatic test_nominal();
        int bad = 0;
        int high = 0;
        for (int i = 0; i < 60; i++) begin
            wait_fall();
            if (last_period != 80) bad++;
        end
        check(bad == 0, "R2 R8 free-running periods", bad, 0);
        do begin tick(); if (bit_clk) high++; end while (!fell_now);
        check(high == 40, "R2 high time", high, 40);
    endtask

    task automatic test_lock();
        for (int i = 0; i < 4; i++) begin
            strobe_at(0, 1'b0);
            wait_fall();
            check(last_period == 80, "R6 aligned strobe", last_period, 80);
            check(locked == (i == 3), "R9 lock after quiet frames", locked, (i == 3));
        end
        corr_case(10, 1'b0, 81, "R4 R5 late");
        check(locked == 1'b1, "R10 single correction keeps lock", locked, 1);
        corr_case(60, 1'b0, 79, "R4 R5 early");
        check(locked == 1'b1, "R10 opposite direction keeps lock", locked, 1);
        corr_case(60, 1'b0, 79, "R4 R5 early again");
        check(locked == 1'b0, "R10 two same-direction corrections", locked, 0);
    endtask

    task automatic test_steps();
        corr_case(10, 1'b0, 81, "R5 late step1");
        corr_case(2,  1'b1, 82, "R5 late step2 edge of band");
        corr_case(60, 1'b0, 79, "R5 early step1");
        corr_case(60, 1'b1, 78, "R5 early step2");
        corr_case(1,  1'b1, 80, "R6 late by one");
        corr_case(79, 1'b1, 80, "R6 early by one at boundary");
    endtask

    task automatic test_window();
        strobe_at(0, 1'b0);
        wait_fall();
        repeat (10) tick();
        frm_strobe = 1'b1;
        step_sel   = 1'b1;
        tick();
        frm_strobe = 1'b0;
        wait_fall();
        check(last_period == 80, "R7 second strobe current period", last_period, 80);
        wait_fall();
        check(last_period == 80, "R7 second strobe ignored", last_period, 80);
    endtask

    initial begin
        test_reset();
        test_nominal();
        test_lock();
        test_steps();
        test_window();
        check(tx_err == 0, "R11 transmit clock mismatches", tx_err, 0);
        check(ref_err == 0, "R3 reference alignment errors", ref_err, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule